// File: doc/BRIEF.md
# Serial Attenuator Control Register

This block is the digital side of a three-wire serial port that programs two 5-bit step attenuators. A host drives a serial clock, a data line and a select line. On every rising edge of the serial clock, the block shifts one data bit into a 10-bit register, whatever the level of the select line. A rising edge on the select line then copies the whole word into two 5-bit attenuator control registers. The attenuators change state at that moment and at no other.

Each attenuator control field is active-low. A 0 in a bit position switches that step in, and the steps are binary weighted. The block gives out the raw control codes for the switch drivers and also a decoded attenuation figure in dB. It also brings in an active-low loopback-mixer enable and turns it into an active-high enable.

All logic runs on one system clock. The serial clock, data, select and loopback-enable inputs are re-timed by two-flop synchronizers. The system clock must run at four times the serial clock rate or faster.

Top module: `atten_serial_ctrl`

## Requirements
- R1: After reset, both attenuator codes read 5'b11111, both dB outputs read 0, and the loopback enable output is 0. The shift register is cleared.
- R2: Each serial-clock rising edge shifts the data line into bit 0 of the word. Earlier bits move toward bit 9, so the first of ten bits sent lands in bit 9.
- R3: Shifting goes on while the select line is high as well as while it is low. A select rising edge latches whatever the word holds at that time.
- R4: The attenuator codes and dB outputs change only on a select rising edge. Serial clocks alone and select falling edges leave them unchanged.
- R5: Word bits 9..5 form the attenuator A code, and word bits 4..0 form the attenuator B code.
- R6: The dB output of each attenuator is 31 minus its code. Within a field the bits weigh 16, 8, 4, 2 and 1 dB from MSB to LSB. Code 11111 gives 0 dB and code 00000 gives 31 dB.
- R7: When more than ten serial clocks come before a select rising edge, the last ten bits shifted in are the ones latched.
- R8: The loopback enable output is the inverse of the active-low loopback input. A change on the input reaches the output on the second system clock edge after it.
- R9: A serial-clock or select rising edge takes effect on the third system clock edge after the input rises, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_dat_i | input | 1 | Serial data from host |
| ser_sel_i | input | 1 | Select line; its rising edge commits the word |
| loop_en_n_i | input | 1 | Loopback mixer enable, active-low |
| att_a_code_o | output | 5 | Attenuator A control code (active-low steps) |
| att_b_code_o | output | 5 | Attenuator B control code (active-low steps) |
| att_a_db_o | output | 5 | Attenuator A setting in dB |
| att_b_db_o | output | 5 | Attenuator B setting in dB |
| loop_en_o | output | 1 | Loopback mixer enable, active-high |

## Verification
A select rising edge shows up on the attenuator outputs after the third system clock edge: two synchronizer flops, then the latch. The loopback output follows its input after the second edge. The bench drives inputs at falling edges of the system clock and counts rising edges before it samples. It reads the outputs after edge two, where the old value must still stand, and after edge three, where the new value must show. Serial bits are held for four system cycles per half period, so each one is shifted before the next edge comes.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ATT_FIELD_W = 5;
  localparam int ATT_COUNT   = 2;
  localparam int SYNC_DEPTH  = 2;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = din;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign lvl = stage_q[STAGES-1];
endmodule

// File: rtl/shift_word.sv
module shift_word #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;

  assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word_q == {$past(word_q[W-2:0]), $past(din)}));
  assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));
endmodule

// File: rtl/atten_bank.sv
module atten_bank #(
  parameter int FIELD_W = 5,
  parameter int N_ATT   = 2,
  localparam int WORD_W = FIELD_W * N_ATT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] code,
  output logic [WORD_W-1:0] db
);
  localparam logic [FIELD_W-1:0] FULL_SCALE = {FIELD_W{1'b1}};

  logic [WORD_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (commit) code_d = word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= {WORD_W{1'b1}};
    else        code_q <= code_d;
  end

  for (genvar g = 0; g < N_ATT; g++) begin : g_decode
    assign db[g*FIELD_W +: FIELD_W] = FULL_SCALE - code_q[g*FIELD_W +: FIELD_W];
  end

  assign code = code_q;

  assert_hold_without_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(code_q));
  assert_load_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (code_q == $past(word)));
endmodule

// File: rtl/atten_serial_ctrl.sv
module atten_serial_ctrl #(
  parameter int FIELD_W = atten_pkg::ATT_FIELD_W,
  parameter int STAGES  = atten_pkg::SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  input  logic               ser_sel_i,
  input  logic               loop_en_n_i,
  output logic [FIELD_W-1:0] att_a_code_o,
  output logic [FIELD_W-1:0] att_b_code_o,
  output logic [FIELD_W-1:0] att_a_db_o,
  output logic [FIELD_W-1:0] att_b_db_o,
  output logic               loop_en_o
);
  localparam int N_ATT  = atten_pkg::ATT_COUNT;
  localparam int WORD_W = FIELD_W * N_ATT;
  localparam int I_DAT  = 0;
  localparam int I_CLK  = 1;
  localparam int I_SEL  = 2;
  localparam int I_LOOP = 3;

  logic [3:0]        raw_in, sync_lvl;
  logic              sclk_prev_q, sel_prev_q;
  logic              sclk_rise, sel_rise;
  logic [WORD_W-1:0] word, code, db;

  assign raw_in = {loop_en_n_i, ser_sel_i, ser_clk_i, ser_dat_i};

  bit_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw_in), .lvl(sync_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      sel_prev_q  <= 1'b1;
    end else begin
      sclk_prev_q <= sync_lvl[I_CLK];
      sel_prev_q  <= sync_lvl[I_SEL];
    end
  end

  assign sclk_rise = sync_lvl[I_CLK] & ~sclk_prev_q;
  assign sel_rise  = sync_lvl[I_SEL] & ~sel_prev_q;

  shift_word #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
    .din(sync_lvl[I_DAT]), .word(word)
  );

  atten_bank #(.FIELD_W(FIELD_W), .N_ATT(N_ATT)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(sel_rise),
    .word(word), .code(code), .db(db)
  );

  assign att_a_code_o = code[WORD_W-1 -: FIELD_W];
  assign att_b_code_o = code[FIELD_W-1:0];
  assign att_a_db_o   = db[WORD_W-1 -: FIELD_W];
  assign att_b_db_o   = db[FIELD_W-1:0];
  assign loop_en_o    = ~sync_lvl[I_LOOP];

  assert_single_clk_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
  assert_single_sel_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> !sel_rise);
endmodule

// File: tb/test_atten_serial_ctrl.sv
module test_atten_serial_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_sel = 1'b1, loop_n = 1'b1;
  logic [4:0] a_code, b_code, a_db, b_db;
  logic loop_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  atten_serial_ctrl i_atten_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_sel_i(ser_sel), .loop_en_n_i(loop_n),
    .att_a_code_o(a_code), .att_b_code_o(b_code),
    .att_a_db_o(a_db), .att_b_db_o(b_db), .loop_en_o(loop_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      ser_dat = w[k];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
    end
    wait_cyc(4);
  endtask

  task automatic pulse_sel();
    ser_sel = 1'b0;
    wait_cyc(4);
    ser_sel = 1'b1;
    wait_cyc(4);
  endtask

  task automatic expect_out(input string req, input logic [9:0] w);
    check({req, " A code"}, a_code, w[9:5]);
    check({req, " B code"}, b_code, w[4:0]);
    check({req, " A dB"}, a_db, 31 - w[9:5]);
    check({req, " B dB"}, b_db, 31 - w[4:0]);
  endtask

  task automatic t_reset();
    check("R1 A code", a_code, 31);
    check("R1 B code", b_code, 31);
    check("R1 A dB", a_db, 0);
    check("R1 B dB", b_db, 0);
    check("R1 loop", loop_en, 0);
  endtask

  task automatic t_commit_timing();
    ser_sel = 1'b0;
    wait_cyc(2);
    send_bits(16'h02A5, 10);
    expect_out("R4 before commit", 10'h3FF);
    ser_sel = 1'b1;
    wait_cyc(2);
    expect_out("R9 two edges", 10'h3FF);
    wait_cyc(1);
    expect_out("R9 three edges", 10'h2A5);
    ser_sel = 1'b0;
    wait_cyc(6);
    expect_out("R4 falling select", 10'h2A5);
    ser_sel = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_sel_high_shift();
    send_bits(16'h01F0, 10);
    expect_out("R3 no commit yet", 10'h2A5);
    pulse_sel();
    expect_out("R3 shifted while high", 10'h1F0);
  endtask

  task automatic t_fields();
    send_bits(16'h01FE, 10);
    pulse_sel();
    expect_out("R5 A=01111 B=11110", 10'h1FE);
    check("R6 A 16dB", a_db, 16);
    check("R6 B 1dB", b_db, 1);
    send_bits(16'h0000, 10);
    pulse_sel();
    check("R6 all zero A", a_db, 31);
    check("R6 all zero B", b_db, 31);
    for (int p = 0; p < 10; p++) begin
      logic [9:0] w;
      w = ~(10'd1 << p);
      send_bits({6'd0, w}, 10);
      pulse_sel();
      if (p >= 5) check("R6 weight A", a_db, 1 << (p - 5));
      else        check("R6 weight B", b_db, 1 << p);
      check("R5 other field 0dB", (p >= 5) ? b_db : a_db, 0);
    end
  endtask

  task automatic t_overrun();
    send_bits(16'h1633, 13);
    pulse_sel();
    expect_out("R7 last ten bits", 10'h233);
    send_bits(16'h0001, 2);
    pulse_sel();
    expect_out("R2 partial word shift", 10'h0CD);
  endtask

  task automatic t_loop();
    loop_n = 1'b0;
    wait_cyc(1);
    check("R8 one edge", loop_en, 0);
    wait_cyc(1);
    check("R8 enabled", loop_en, 1);
    expect_out("R8 no attenuator effect", 10'h0CD);
    loop_n = 1'b1;
    wait_cyc(2);
    check("R8 disabled", loop_en, 0);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_commit_timing();
    t_sel_high_shift();
    t_fields();
    t_overrun();
    t_loop();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule